// File: doc/BRIEF.md
# Hot-Insertion Two-Wire Bus Link Controller

This block controls when a card-side two-wire bus (data and clock) is joined to a live backplane bus during and after hot insertion. While the supply is not yet good it keeps the two sides apart and ignores all line activity. Once power is good, it waits for the backplane side to finish its current transfer before joining the sides. A transfer counts as finished on a stop condition or after both backplane lines have stayed high for a programmable idle time. The card-side lines must also be high at that moment.

When the sides are joined, each line behaves as a single wired-AND net spanning both sides. The block samples the level of every line and drives the opposite side low through an open-drain style enable. A direction tracker per line stops the block from latching a line low with its own drive. A connection-status output, an enable input, a stuck-bus fault input from a separate recovery block, and a disable output to that block complete the control path. An enable rising edge that follows a fault forces the join at once.

Top module: `hsbus_link_ctrl`

## Requirements
- R1: While `pwr_good` is 0 the sides stay apart. `ready` is 0 from the next clock edge, every `*_oe` output is 0, and line activity has no effect on any output.
- R2: A stop condition is a rising edge on synchronised backplane data while synchronised backplane clock is high. It qualifies the link at once. A data rising edge while the clock is low does not qualify it.
- R3: Bus idle means both synchronised backplane lines are high for IDLE_NS × CLK_MHZ / 1000 clock cycles, rounded up. The count restarts whenever either backplane line is low. Idle qualifies the link.
- R4: In normal operation the link closes only after R2 or R3 has qualified it and both card-side lines read high. `ready` is 1 exactly while the link is closed.
- R5: While the link is closed, a line held low on either side is driven low on the other side (`*_oe` = 1 means drive low). The line returns high only when no device on either side holds it. No `*_oe` output is ever 1 while `ready` is 0.
- R6: `enable` = 0 opens the link on the next edge and forces `ready` to 0. `recov_disable` then reads 1 one cycle after `enable` falls.
- R7: When `enable` returns to 1 with no fault pending, the controller again waits for R2 or R3 and for card lines high.
- R8: An `enable` rising edge while a fault is pending closes the link on that edge, whatever the line levels.
- R9: A rising edge on `stuck_fault` opens the link and marks a fault pending. Reconnection then follows R4. A fault edge wins over a qualification arriving in the same cycle, and that qualification is discarded.
- R10: During reset `ready` is 0, every `*_oe` is 0 and `recov_disable` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good | input | 1 | Supply good; 0 holds lockout |
| enable | input | 1 | Connection enable |
| stuck_fault | input | 1 | Stuck-bus fault from the recovery block |
| bp_sda_i | input | 1 | Backplane data line level |
| bp_scl_i | input | 1 | Backplane clock line level |
| card_sda_i | input | 1 | Card data line level |
| card_scl_i | input | 1 | Card clock line level |
| bp_sda_oe | output | 1 | Pull backplane data low |
| bp_scl_oe | output | 1 | Pull backplane clock low |
| card_sda_oe | output | 1 | Pull card data low |
| card_scl_oe | output | 1 | Pull card clock low |
| ready | output | 1 | Link closed |
| recov_disable | output | 1 | Disables the recovery block's clocking |

## Verification
A stuck-bus fault edge and a stop condition on the backplane can reach the controller in the same clock cycle. Here the fault must win, and the stop must not be remembered. The bench provokes this by releasing backplane data while clock is high and counting the two synchroniser edges. It then raises `stuck_fault` just before the edge on which the stop pulse is seen. It checks that `ready` stays 0 past the stop and rises only after a full idle period.

// File: rtl/hsbus_pkg.sv
// Shared types and helpers for the hot-insertion link controller.
// Assumes a single clock domain for all control inputs.
package hsbus_pkg;

    // Link controller states
    typedef enum logic [1:0] {
        LNK_LOCK = 2'd0,
        LNK_WAIT = 2'd1,
        LNK_JOIN = 2'd2
    } link_state_t;

    // Per-line drive direction while joined
    typedef enum logic [1:0] {
        DIR_NONE   = 2'd0,
        DIR_BP2CD  = 2'd1,
        DIR_CD2BP  = 2'd2,
        DIR_SETTLE = 2'd3
    } dir_state_t;

    localparam int LINE_SDA  = 0;
    localparam int LINE_SCL  = 1;
    localparam int NUM_LINES = 2;

    // Idle time in clock cycles, rounded up, never below one
    function automatic int idle_cycles(input int clk_mhz, input int idle_ns);
        int c;
        c = (clk_mhz * idle_ns + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/hsbus_sync.sv
// Multi-stage synchroniser for a vector of asynchronous line levels.
// Assumes the lines idle high; the reset value is a parameter.
module hsbus_sync #(
    parameter int              WIDTH   = 4,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] pipe [STAGES];

    // Shift raw levels through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/hsbus_end_detect.sv
// Watches the synchronised backplane lines for the end of a transfer.
// It reports a one-cycle stop pulse and a level that is high once the bus
// has been idle for IDLE_CYC cycles. hold_clr keeps the detector
// quiet during lockout.
module hsbus_end_detect #(
    parameter int IDLE_CYC = 9500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_clr,
    input  logic sda_hi,
    input  logic scl_hi,
    output logic stop_seen,
    output logic idle_met
);

    localparam int            CW    = $clog2(IDLE_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(IDLE_CYC);

    logic [CW-1:0] idle_cnt;
    logic          sda_prev;

    // Remember the previous data level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sda_prev <= 1'b1;
        else        sda_prev <= sda_hi;
    end

    // Count consecutive cycles with both lines high, saturating
    always_ff @(posedge clk) begin
        if (!rst_n || hold_clr || !(sda_hi && scl_hi)) idle_cnt <= '0;
        else if (idle_cnt != LIMIT)                    idle_cnt <= idle_cnt + 1'b1;
    end

    assign stop_seen = sda_hi && !sda_prev && scl_hi && !hold_clr;
    assign idle_met  = (idle_cnt == LIMIT);

endmodule

// File: rtl/hsbus_line_bridge.sv
// Wired-AND bridge for one line between the backplane and the card.
// A side held low by an outside device is mirrored onto the other side. The
// tracker remembers which side it is driving, so it never mistakes its own
// pull for an outside one. After a release it waits out the synchroniser
// latency before it looks again.
module hsbus_line_bridge
    import hsbus_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic link,
    input  logic bp_lo,
    input  logic cd_lo,
    output logic bp_oe,
    output logic cd_oe
);

    localparam int            HOLD_CYC  = SYNC_STAGES + 1;
    localparam int            CW        = $clog2(HOLD_CYC);
    localparam logic [CW-1:0] HOLD_LOAD = CW'(HOLD_CYC - 1);

    dir_state_t    dir;
    logic [CW-1:0] settle_cnt;

    // Track drive direction and the settle window after a release
    always_ff @(posedge clk) begin
        if (!rst_n || !link) begin
            dir        <= DIR_NONE;
            settle_cnt <= '0;
        end else begin
            case (dir)
                DIR_NONE: begin
                    if (bp_lo)      dir <= DIR_BP2CD;
                    else if (cd_lo) dir <= DIR_CD2BP;
                end
                DIR_BP2CD: begin
                    if (!bp_lo) begin
                        dir        <= DIR_SETTLE;
                        settle_cnt <= HOLD_LOAD;
                    end
                end
                DIR_CD2BP: begin
                    if (!cd_lo) begin
                        dir        <= DIR_SETTLE;
                        settle_cnt <= HOLD_LOAD;
                    end
                end
                default: begin
                    if (settle_cnt == '0) dir <= DIR_NONE;
                    else                  settle_cnt <= settle_cnt - 1'b1;
                end
            endcase
        end
    end

    assign cd_oe = link && (dir == DIR_BP2CD);
    assign bp_oe = link && (dir == DIR_CD2BP);

endmodule

// File: rtl/hsbus_link_ctrl.sv
// Hot-insertion link controller: decides when the card bus joins the
// backplane bus and bridges both lines while joined.
// Assumes pwr_good, enable and stuck_fault are synchronous to clk. The bus
// lines are asynchronous and pass through synchronisers.
module hsbus_link_ctrl
    import hsbus_pkg::*;
#(
    parameter int CLK_MHZ     = 100,
    parameter int IDLE_NS     = 95000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic enable,
    input  logic stuck_fault,
    input  logic bp_sda_i,
    input  logic bp_scl_i,
    input  logic card_sda_i,
    input  logic card_scl_i,
    output logic bp_sda_oe,
    output logic bp_scl_oe,
    output logic card_sda_oe,
    output logic card_scl_oe,
    output logic ready,
    output logic recov_disable
);

    localparam int IDLE_CYC = idle_cycles(CLK_MHZ, IDLE_NS);

    logic [3:0]           line_s;
    logic [NUM_LINES-1:0] bp_lo, cd_lo, bp_oe_v, cd_oe_v;
    logic                 stop_seen, idle_met, qualified, card_hi;
    logic                 en_prev, flt_prev, en_rise, flt_rise;
    logic                 end_seen, fault_pend, link;
    link_state_t          state;

    hsbus_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1111)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({card_scl_i, card_sda_i, bp_scl_i, bp_sda_i}),
        .q     (line_s)
    );

    assign bp_lo[LINE_SDA] = !line_s[0];
    assign bp_lo[LINE_SCL] = !line_s[1];
    assign cd_lo[LINE_SDA] = !line_s[2];
    assign cd_lo[LINE_SCL] = !line_s[3];
    assign card_hi         = line_s[2] && line_s[3];

    hsbus_end_detect #(.IDLE_CYC(IDLE_CYC)) i_end (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_clr  (!pwr_good),
        .sda_hi    (line_s[0]),
        .scl_hi    (line_s[1]),
        .stop_seen (stop_seen),
        .idle_met  (idle_met)
    );

    assign qualified = end_seen || stop_seen || idle_met;
    assign en_rise   = enable && !en_prev;
    assign flt_rise  = stuck_fault && !flt_prev;
    assign link      = (state == LNK_JOIN);

    // Edge history for enable and fault inputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_prev  <= 1'b0;
            flt_prev <= 1'b0;
        end else begin
            en_prev  <= enable;
            flt_prev <= stuck_fault;
        end
    end

    // Link state machine with priority lockout > enable > fault > force > normal
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= LNK_LOCK;
            end_seen   <= 1'b0;
            fault_pend <= 1'b0;
        end else if (!pwr_good) begin
            state      <= LNK_LOCK;
            end_seen   <= 1'b0;
            fault_pend <= 1'b0;
        end else if (!enable) begin
            state    <= LNK_WAIT;
            end_seen <= 1'b0;
        end else if (flt_rise) begin
            state      <= LNK_WAIT;
            end_seen   <= 1'b0;
            fault_pend <= 1'b1;
        end else if (en_rise && fault_pend) begin
            state      <= LNK_JOIN;
            end_seen   <= 1'b0;
            fault_pend <= 1'b0;
        end else begin
            case (state)
                LNK_LOCK: state <= LNK_WAIT;
                LNK_WAIT: begin
                    if (qualified && card_hi) begin
                        state      <= LNK_JOIN;
                        end_seen   <= 1'b0;
                        fault_pend <= 1'b0;
                    end else begin
                        end_seen <= qualified;
                    end
                end
                LNK_JOIN: state <= LNK_JOIN;
                default:  state <= LNK_LOCK;
            endcase
        end
    end

    // Disable request to the recovery block follows enable
    always_ff @(posedge clk) begin
        if (!rst_n) recov_disable <= 1'b1;
        else        recov_disable <= !enable;
    end

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        hsbus_line_bridge #(.SYNC_STAGES(SYNC_STAGES)) i_bridge (
            .clk   (clk),
            .rst_n (rst_n),
            .link  (link),
            .bp_lo (bp_lo[g]),
            .cd_lo (cd_lo[g]),
            .bp_oe (bp_oe_v[g]),
            .cd_oe (cd_oe_v[g])
        );
    end

    assign bp_sda_oe   = bp_oe_v[LINE_SDA];
    assign bp_scl_oe   = bp_oe_v[LINE_SCL];
    assign card_sda_oe = cd_oe_v[LINE_SDA];
    assign card_scl_oe = cd_oe_v[LINE_SCL];
    assign ready       = link;

endmodule

// File: rtl/hsbus_link_ctrl_chk.sv
// Property checker for the link controller, attached by bind.
module hsbus_link_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic pwr_good,
    input logic enable,
    input logic stuck_fault,
    input logic ready,
    input logic recov_disable,
    input logic [3:0] oe_all
);

    // R1: lockout opens the link
    assert_lockout_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> !ready);

    // R1: lockout releases every line
    assert_lockout_drive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> (oe_all == 4'b0000));

    // R6: enable low opens the link and disables recovery
    assert_enable_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!ready && recov_disable));

    // R9: fault edge opens the link
    assert_fault_break_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stuck_fault) |=> !ready);

    // R5: no drive without a closed link
    assert_drive_needs_link_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_all != 4'b0000) |-> ready);

endmodule

bind hsbus_link_ctrl hsbus_link_ctrl_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pwr_good      (pwr_good),
    .enable        (enable),
    .stuck_fault   (stuck_fault),
    .ready         (ready),
    .recov_disable (recov_disable),
    .oe_all        ({bp_sda_oe, bp_scl_oe, card_sda_oe, card_scl_oe})
);

// File: tb/test_hsbus_link_ctrl.sv
module test_hsbus_link_ctrl;

    // pull/lvl bit order: [3] bp data, [2] bp clock, [1] card data, [0] card clock
    typedef struct packed {
        logic       pg;
        logic       en;
        logic       flt;
        logic [3:0] pull;
        logic [7:0] hold;
        logic       rdy;
        logic       dis;
        logic [3:0] lvl;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 34;
    localparam vec_t TBL [NV] = '{
        '{1'b0,1'b1,1'b0,4'b0000,8'd40,1'b0,1'b0,4'b1111,4'd1},  // R1 lockout
        '{1'b0,1'b1,1'b0,4'b0010,8'd10,1'b0,1'b0,4'b1101,4'd1},  // R1 activity ignored
        '{1'b1,1'b1,1'b0,4'b0010,8'd45,1'b0,1'b0,4'b1101,4'd4},  // R4 card low blocks
        '{1'b1,1'b1,1'b0,4'b0000,8'd6, 1'b1,1'b0,4'b1111,4'd4},  // R4 joins
        '{1'b1,1'b1,1'b0,4'b1000,8'd6, 1'b1,1'b0,4'b0101,4'd5},  // R5 bp data -> card
        '{1'b1,1'b1,1'b0,4'b0000,8'd8, 1'b1,1'b0,4'b1111,4'd5},
        '{1'b1,1'b1,1'b0,4'b0001,8'd6, 1'b1,1'b0,4'b1010,4'd5},  // R5 card clock -> bp
        '{1'b1,1'b1,1'b0,4'b0101,8'd6, 1'b1,1'b0,4'b1010,4'd5},
        '{1'b1,1'b1,1'b0,4'b0100,8'd10,1'b1,1'b0,4'b1010,4'd5},
        '{1'b1,1'b1,1'b0,4'b0101,8'd6, 1'b1,1'b0,4'b1010,4'd5},
        '{1'b1,1'b1,1'b0,4'b0001,8'd12,1'b1,1'b0,4'b1010,4'd5},
        '{1'b1,1'b1,1'b0,4'b0000,8'd8, 1'b1,1'b0,4'b1111,4'd5},
        '{1'b1,1'b0,1'b0,4'b0000,8'd4, 1'b0,1'b1,4'b1111,4'd6},  // R6 enable low
        '{1'b1,1'b0,1'b0,4'b1000,8'd5, 1'b0,1'b1,4'b0111,4'd6},
        '{1'b1,1'b1,1'b0,4'b1000,8'd50,1'b0,1'b0,4'b0111,4'd7},  // R7 waits again
        '{1'b1,1'b1,1'b0,4'b0000,8'd6, 1'b1,1'b0,4'b1111,4'd2},  // R2 stop joins
        '{1'b1,1'b0,1'b0,4'b1100,8'd3, 1'b0,1'b1,4'b0011,4'd6},
        '{1'b1,1'b1,1'b0,4'b1100,8'd10,1'b0,1'b0,4'b0011,4'd7},
        '{1'b1,1'b1,1'b0,4'b0100,8'd10,1'b0,1'b0,4'b1011,4'd2},  // R2 no stop, clock low
        '{1'b1,1'b1,1'b0,4'b0000,8'd10,1'b0,1'b0,4'b1111,4'd3},  // R3 idle not yet
        '{1'b1,1'b1,1'b0,4'b0000,8'd25,1'b1,1'b0,4'b1111,4'd3},  // R3 idle reached
        '{1'b1,1'b1,1'b0,4'b0010,8'd6, 1'b1,1'b0,4'b0101,4'd5},
        '{1'b1,1'b1,1'b1,4'b0010,8'd4, 1'b0,1'b0,4'b1101,4'd9},  // R9 fault opens
        '{1'b1,1'b1,1'b0,4'b0010,8'd10,1'b0,1'b0,4'b1101,4'd9},
        '{1'b1,1'b1,1'b0,4'b0000,8'd25,1'b1,1'b0,4'b1111,4'd9},  // R9 normal rejoin
        '{1'b1,1'b1,1'b0,4'b1000,8'd6, 1'b1,1'b0,4'b0101,4'd5},
        '{1'b1,1'b1,1'b1,4'b1000,8'd4, 1'b0,1'b0,4'b0111,4'd9},
        '{1'b1,1'b0,1'b0,4'b1000,8'd3, 1'b0,1'b1,4'b0111,4'd6},
        '{1'b1,1'b1,1'b0,4'b1000,8'd6, 1'b1,1'b0,4'b0101,4'd8},  // R8 forced join
        '{1'b1,1'b1,1'b0,4'b0000,8'd6, 1'b1,1'b0,4'b1111,4'd5},
        '{1'b1,1'b0,1'b0,4'b1000,8'd3, 1'b0,1'b1,4'b0111,4'd6},
        '{1'b1,1'b1,1'b0,4'b1000,8'd10,1'b0,1'b0,4'b0111,4'd7},  // R7 no force w/o fault
        '{1'b1,1'b1,1'b0,4'b0000,8'd6, 1'b1,1'b0,4'b1111,4'd2},
        '{1'b0,1'b1,1'b0,4'b0000,8'd3, 1'b0,1'b0,4'b1111,4'd1}   // R1 lockout again
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pg = 1'b0, en = 1'b1, flt = 1'b0;
    logic [3:0] pull = 4'b0000;
    logic bp_sda_oe, bp_scl_oe, card_sda_oe, card_scl_oe, ready, recov_disable;
    logic bp_sda, bp_scl, card_sda, card_scl;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    // Open-drain bus model: a line is low if anyone pulls it
    assign bp_sda   = !(pull[3] || bp_sda_oe);
    assign bp_scl   = !(pull[2] || bp_scl_oe);
    assign card_sda = !(pull[1] || card_sda_oe);
    assign card_scl = !(pull[0] || card_scl_oe);

    hsbus_link_ctrl #(.CLK_MHZ(100), .IDLE_NS(300), .SYNC_STAGES(2)) i_hsbus_link_ctrl (
        .clk(clk), .rst_n(rst_n), .pwr_good(pg), .enable(en), .stuck_fault(flt),
        .bp_sda_i(bp_sda), .bp_scl_i(bp_scl), .card_sda_i(card_sda), .card_scl_i(card_scl),
        .bp_sda_oe(bp_sda_oe), .bp_scl_oe(bp_scl_oe),
        .card_sda_oe(card_sda_oe), .card_scl_oe(card_scl_oe),
        .ready(ready), .recov_disable(recov_disable)
    );

    task automatic check1(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual running expected finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R10 reset state
        repeat (3) @(negedge clk);
        check1("R10", "ready", ready, 1'b0);
        check1("R10", "recov_disable", recov_disable, 1'b1);
        check1("R10", "oe", bp_sda_oe | bp_scl_oe | card_sda_oe | card_scl_oe, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d row%0d", TBL[i].req, i);
            pg = TBL[i].pg; en = TBL[i].en; flt = TBL[i].flt; pull = TBL[i].pull;
            repeat (TBL[i].hold) @(negedge clk);
            check1(tag, "ready", ready, TBL[i].rdy);
            check1(tag, "recov_disable", recov_disable, TBL[i].dis);
            check1(tag, "bp_sda", bp_sda, TBL[i].lvl[3]);
            check1(tag, "bp_scl", bp_scl, TBL[i].lvl[2]);
            check1(tag, "card_sda", card_sda, TBL[i].lvl[1]);
            check1(tag, "card_scl", card_scl, TBL[i].lvl[0]);
        end

        // R9 versus R2 in the same cycle: fault edge meets the stop pulse
        @(negedge clk);
        pg = 1'b1; en = 1'b0; pull = 4'b1000;
        repeat (5) @(negedge clk);
        en = 1'b1;
        repeat (5) @(negedge clk);
        check1("R7", "ready before stop", ready, 1'b0);
        pull = 4'b0000;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        flt = 1'b1;
        repeat (6) @(negedge clk);
        check1("R9", "ready after fault with stop", ready, 1'b0);
        flt = 1'b0;
        repeat (40) @(negedge clk);
        check1("R3", "ready after idle", ready, 1'b1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule